// File: doc/BRIEF.md
# Parallel ROM Read Cycle Controller

This block lets a synchronous processor port read a byte-wide asynchronous parallel ROM that has active-low chip-enable and output-enable pins. A request carries a 16-bit address. The controller places the address on the ROM pins and pulls chip enable low. It lowers output enable only late enough in the cycle that the output-enable delay ends at the same edge as the address access time. It captures the byte on that edge and returns it with a one-cycle done pulse. Both enables are released on that same edge.

After the release, the ROM drivers need time to let go of the data lines. The block reports this with a bus-free flag and starts no new access until the flag is back high. Requests that arrive while a read is in progress wait in a small in-order queue. All wait lengths come from the clock period parameter in nanoseconds and a 2-bit speed-grade input. Each nanosecond figure becomes a number of cycles: the ceiling of the figure divided by the clock period, never less than one.

Top module: `prom_rd_ctrl`

## Requirements
- R1: After reset, romCeN and romOeN are 1, rdDone is 0 and busFree is 1.
- R2: speedGrade is sampled when a read starts. Code 2'b00 selects a 120 ns access, 2'b01 selects 150 ns, and 2'b10 and 2'b11 both select 200 ns. romCeN stays low for exactly ceil(access/CLK_NS) cycles, with a minimum of 1.
- R3: romOeN goes low only while romCeN is low. It stays low for exactly ceil(50/CLK_NS) cycles, ending at the same edge as romCeN.
- R4: At the edge that ends the access, the value on romData is captured. It appears on rdData together with rdDone.
- R5: romCeN and romOeN return high at the same edge, and rdDone is high in the cycle that follows that edge.
- R6: rdDone is high for exactly one cycle per completed read.
- R7: busFree goes low when a read starts. It returns high exactly ceil(30/CLK_NS) cycles after the enables are released. romCeN never falls while busFree is low, so it stays high for at least that many cycles between reads.
- R8: Requests with reqValid high are served in arrival order. Up to PEND_DEPTH of them can wait beyond the one in service. A request that arrives while PEND_DEPTH requests are waiting is dropped and never completes.
- R9: romAddr equals the request address when romCeN falls and stays stable while romCeN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request strobe, one request per cycle high |
| reqAddr | input | 16 | Read address |
| speedGrade | input | 2 | ROM speed-grade code |
| romAddr | output | 16 | ROM address pins |
| romCeN | output | 1 | ROM chip enable, active low |
| romOeN | output | 1 | ROM output enable, active low |
| romData | input | 8 | ROM data pins |
| rdData | output | 8 | Captured read byte |
| rdDone | output | 1 | One-cycle read completion pulse |
| busFree | output | 1 | High when ROM outputs have floated and no read is active |

## Verification
Single reads are issued from idle at each of the four grade codes, at the lowest, highest and mixed addresses. The bench's ROM model returns a corrupt byte until the real nanosecond access, enable and output-enable delays have passed. These reads therefore separate a correct capture edge from one that is a cycle early. They also show whether code 2'b11 is treated as the slowest grade. A back-to-back burst one request longer than the queue can hold tests three things: in-order service, the float gap between consecutive reads, and the dropping of the overflow request. A dropped request would otherwise show up as an extra done pulse.

// File: rtl/prom_rd_pkg.sv
`timescale 1ns/1ps
package prom_rd_pkg;

  typedef enum logic [1:0] {
    GR_FAST  = 2'b00,
    GR_MID   = 2'b01,
    GR_SLOW  = 2'b10,
    GR_SLOW2 = 2'b11
  } grade_e;

  typedef struct packed {
    logic start;   // address + chip enable go active
    logic oeOn;    // output enable goes active
    logic finish;  // capture data, release both enables
  } strobe_t;

  // ceiling of ns/per, never below one cycle
  function automatic int nsToCyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/prom_rd_fifo.sv
`timescale 1ns/1ps
module prom_rd_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             full, doPush, doPop;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  // R8: occupancy never exceeds the queue depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  // R8: a push into a full queue leaves occupancy unchanged unless popped
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> full);

endmodule

// File: rtl/prom_rd_fsm.sv
`timescale 1ns/1ps
module prom_rd_fsm
  import prom_rd_pkg::*;
#(
  parameter int CLK_NS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pendEmpty,
  input  logic [1:0] speedGrade,
  output logic      pendPop,
  output strobe_t   strb,
  output logic      busFree
);
  localparam int ACC_FAST = nsToCyc(120, CLK_NS);
  localparam int ACC_MID  = nsToCyc(150, CLK_NS);
  localparam int ACC_SLOW = nsToCyc(200, CLK_NS);
  localparam int OE_CYC   = nsToCyc(50, CLK_NS);
  localparam int FLT_CYC  = nsToCyc(30, CLK_NS);  // covers the 25 ns OE float too
  localparam int CW       = $clog2(ACC_SLOW + FLT_CYC + 2) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_FLOAT} state_e;

  state_e        state;
  logic [CW-1:0] cnt, accLimQ, lagLimQ, accSel, lagSel;
  logic          startNow;

  always_comb begin
    case (grade_e'(speedGrade))
      GR_FAST: accSel = CW'(ACC_FAST);
      GR_MID:  accSel = CW'(ACC_MID);
      default: accSel = CW'(ACC_SLOW);
    endcase
    lagSel = accSel - CW'(OE_CYC);
  end

  assign startNow = (state == S_IDLE) && busFree && !pendEmpty;
  assign pendPop  = startNow;

  always_comb begin
    strb = '0;
    if (startNow) begin
      strb.start = 1'b1;
      strb.oeOn  = (lagSel == '0);
    end else if (state == S_ACCESS) begin
      strb.oeOn   = (lagLimQ != '0) && (cnt == lagLimQ - 1'b1);
      strb.finish = (cnt == accLimQ - 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      accLimQ <= '0;
      lagLimQ <= '0;
      busFree <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (startNow) begin
          state   <= S_ACCESS;
          cnt     <= '0;
          accLimQ <= accSel;
          lagLimQ <= lagSel;
          busFree <= 1'b0;
        end
        S_ACCESS: begin
          cnt <= cnt + 1'b1;
          if (strb.finish) begin
            state <= S_FLOAT;
            cnt   <= '0;
          end
        end
        S_FLOAT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(FLT_CYC - 1)) begin
            state   <= S_IDLE;
            busFree <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: the access counter never runs past the selected limit
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACCESS) |-> (cnt < accLimQ));
  // R7: the bus is never free while an access or float window is running
  a_r7_free_idle: assert property (@(posedge clk) disable iff (!rstN)
    busFree |-> (state == S_IDLE));
  // R3: at most one strobe kind per cycle among start and finish
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.start && strb.finish));

endmodule

// File: rtl/prom_rd_dp.sv
`timescale 1ns/1ps
module prom_rd_dp
  import prom_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] headAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      romAddr <= '0;
      romCeN  <= 1'b1;
      romOeN  <= 1'b1;
      rdData  <= '0;
      rdDone  <= 1'b0;
    end else begin
      rdDone <= strb.finish;
      if (strb.start) begin
        romAddr <= headAddr;
        romCeN  <= 1'b0;
      end
      if (strb.oeOn) romOeN <= 1'b0;
      if (strb.finish) begin
        rdData <= romData;
        romCeN <= 1'b1;
        romOeN <= 1'b1;
      end
    end
  end

  // R3: output enable is only active inside a chip-enable window
  a_r3_oe_in_ce: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romCeN);
  // R5: both enables are released at the same edge, with done following
  a_r5_release_together: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romCeN) |-> ($rose(romOeN) && rdDone));
  // R6: a done pulse never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);
  // R9: the address is held while the chip is enabled
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && $past(!romCeN)) |-> $stable(romAddr));

endmodule

// File: rtl/prom_rd_ctrl.sv
`timescale 1ns/1ps
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int CLK_NS     = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PEND_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        speedGrade,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  input  logic [DATA_W-1:0] romData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone,
  output logic              busFree
);
  logic              pendPop, pendEmpty;
  logic [ADDR_W-1:0] headAddr;
  strobe_t           strb;

  prom_rd_fifo #(.WIDTH(ADDR_W), .DEPTH(PEND_DEPTH)) pend_i (
    .clk(clk), .rstN(rstN),
    .push(reqValid), .pushData(reqAddr),
    .pop(pendPop), .headData(headAddr), .empty(pendEmpty)
  );

  prom_rd_fsm #(.CLK_NS(CLK_NS)) fsm_i (
    .clk(clk), .rstN(rstN),
    .pendEmpty(pendEmpty), .speedGrade(speedGrade),
    .pendPop(pendPop), .strb(strb), .busFree(busFree)
  );

  prom_rd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .headAddr(headAddr),
    .romData(romData), .romAddr(romAddr), .romCeN(romCeN),
    .romOeN(romOeN), .rdData(rdData), .rdDone(rdDone)
  );

  // R7: a new chip-enable window only opens from a free bus
  a_r7_start_when_free: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romCeN) |-> ($past(busFree) && !busFree));

endmodule

// File: tb/prom_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module prom_rd_ctrl_tb_top;
  localparam int CLK_NS = 4;
  localparam int DEPTH  = 4;
  localparam int OE_C   = (50 + CLK_NS - 1) / CLK_NS;
  localparam int FLT_C  = (30 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  speedGrade = 2'b00;
  logic [15:0] romAddr;
  logic        romCeN, romOeN, rdDone, busFree;
  logic [7:0]  romData = '0, rdData;

  prom_rd_ctrl #(.CLK_NS(CLK_NS), .PEND_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .speedGrade(speedGrade), .romAddr(romAddr), .romCeN(romCeN),
    .romOeN(romOeN), .romData(romData), .rdData(rdData),
    .rdDone(rdDone), .busFree(busFree));

  always #(CLK_NS / 2.0) clk = ~clk;

  typedef struct { logic [15:0] addr; logic [7:0] data; int accC; } exp_t;
  exp_t expQ[$];
  int checks = 0, fails = 0, cyc = 0;

  function automatic logic [7:0] romFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic int gradeNs(input logic [1:0] g);
    return (g == 2'b00) ? 120 : (g == 2'b01) ? 150 : 200;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // ROM model: corrupt data until every delay has really elapsed
  real tAddr = 0.0, tCe = 0.0, tOe = 0.0;
  always @(romAddr) tAddr = $realtime;
  always @(negedge romCeN) tCe = $realtime;
  always @(negedge romOeN) tOe = $realtime;
  initial begin
    #0.25;
    forever begin
      real accNs, now;
      accNs = real'(gradeNs(speedGrade));
      now = $realtime;
      if (!romCeN && !romOeN && (now - tAddr >= accNs - 0.5) &&
          (now - tCe >= accNs - 0.5) && (now - tOe >= 49.5))
        romData = romFn(romAddr);
      else
        romData = ~romFn(romAddr);
      #0.5;
    end
  end

  // monitor / scoreboard
  logic prevCe = 1'b1, prevOe = 1'b1, prevDone = 1'b0, prevFree = 1'b1;
  logic [15:0] prevAddr = '0;
  int fallCyc = 0, oeCyc = 0, relCyc = -1000;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      finishRun();
    end
    if (rstN) begin
      if (prevCe && !romCeN) begin
        fallCyc = cyc;
        chk(cyc - relCyc > FLT_C, "R7 ce gap", cyc - relCyc, FLT_C + 1);
        if (expQ.size() > 0)
          chk(romAddr == expQ[0].addr, "R9 address", romAddr, expQ[0].addr);
      end
      if (!prevCe && !romCeN && romAddr != prevAddr)
        chk(1'b0, "R9 stable", romAddr, prevAddr);
      if (prevOe && !romOeN) oeCyc = cyc;
      if (!prevCe && romCeN) begin
        relCyc = cyc;
        chk(romOeN && rdDone, "R5 release", {romOeN, rdDone}, 2'b11);
        chk(cyc - oeCyc == OE_C, "R3 oe width", cyc - oeCyc, OE_C);
        if (expQ.size() > 0)
          chk(cyc - fallCyc == expQ[0].accC, "R2 ce width", cyc - fallCyc, expQ[0].accC);
      end
      if (!prevFree && busFree)
        chk(cyc - relCyc == FLT_C, "R7 float", cyc - relCyc, FLT_C);
      if (rdDone) begin
        if (prevDone) chk(1'b0, "R6 pulse", 2, 1);
        if (expQ.size() == 0) chk(1'b0, "R8 extra done", 1, 0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          chk(rdData == e.data, "R4 data", rdData, e.data);
        end
      end
    end
    prevCe = romCeN; prevOe = romOeN; prevDone = rdDone;
    prevFree = busFree; prevAddr = romAddr;
  end

  task automatic expect1(input logic [15:0] a);
    exp_t e;
    e.addr = a; e.data = romFn(a);
    e.accC = (gradeNs(speedGrade) + CLK_NS - 1) / CLK_NS;
    expQ.push_back(e);
  endtask

  task automatic waitIdle();
    int guard = 0;
    while ((expQ.size() != 0 || !busFree) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R8 all served", expQ.size(), 0);
  endtask

  task automatic single(input logic [1:0] g, input logic [15:0] a);
    @(negedge clk);
    speedGrade = g;
    reqValid = 1'b1; reqAddr = a;
    expect1(a);
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(romCeN == 1'b1, "R1 ceN", romCeN, 1);
    chk(romOeN == 1'b1, "R1 oeN", romOeN, 1);
    chk(rdDone == 1'b0, "R1 done", rdDone, 0);
    chk(busFree == 1'b1, "R1 free", busFree, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R2 each grade code, edge addresses
    single(2'b00, 16'h0000);
    single(2'b01, 16'hFFFF);
    single(2'b10, 16'h1234);
    single(2'b11, 16'hA55A);
    single(2'b00, 16'h8001);
    // R8 burst one longer than the queue holds: last one is dropped
    speedGrade = 2'b01;
    @(negedge clk);
    for (int i = 0; i < DEPTH + 2; i++) begin
      reqValid = 1'b1;
      reqAddr = 16'h3000 + 16'(i * 16'h0111);
      if (i < DEPTH + 1) expect1(reqAddr);
      @(negedge clk);
    end
    reqValid = 1'b0;
    waitIdle();
    repeat (100) @(negedge clk);
    chk(expQ.size() == 0, "R8 dropped request idle", expQ.size(), 0);
    finishRun();
  end
endmodule